// File: doc/BRIEF.md
# Programmable Colour Matrix Converter

This block converts one 4:4:4 video pixel per clock between colour spaces, for example from RGB to YCbCr. It takes three 10-bit unsigned components. Each of the three outputs is a weighted sum of the three inputs plus a constant offset. The nine weights and three offsets are loaded through a plain address/data write port. Each weight is a fixed-point number in sign-magnitude form.

The result is rounded to the nearest code. It then either wraps to 10 bits or is clamped to the legal code range, as selected by a control bit. A bypass control sends the input components straight through. Bypassed pixels take the same number of clocks as converted ones, so downstream timing does not change when the mode is switched.

Top module: `colorspace_conv`

## Requirements
- R1: For each output n, the result is round(sum over k of in[k]·coef[n][k] + 4·offset[n]), where rounding adds one half and takes the floor.
- R2: A weight is written at address 3·n + k. Input index k is 0 = red/Cr, 1 = green/Y, 2 = blue/Cb. Output index n is 0 = Y/G, 1 = Cb/B, 2 = Cr/R. cfg_wdata[15] is the sign (1 = negative). cfg_wdata[14:10] is the integer magnitude. cfg_wdata[9:0] is the fraction magnitude times 1024. The sign negates the product and is not a two's complement of the field.
- R3: Offset n is written at address 9 + n. cfg_wdata[9:0] is read as a two's complement value and is applied multiplied by 4.
- R4: When saturation is on (address 12, bit 1 = 1), a result below 0 outputs 0 and a result above 1023 outputs 1023.
- R5: When saturation is off, the output is the low 10 bits of the rounded result.
- R6: When bypass is on (address 12, bit 0 = 1), each output equals the input of the same index, unchanged.
- R7: pix_valid_o rises exactly 3 clocks after the pixel is sampled, in both modes. Results leave in input order, one per accepted pixel.
- R8: Reset clears all weights and offsets to zero, turns bypass on and saturation off, and drives pix_valid_o and the output data to 0.
- R9: A pixel sampled on the clock after a register write already uses the new value.
- R10: While pix_valid_o is low, the output data hold the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pix_valid_i | input | 1 | Input pixel valid |
| pix0_i | input | 10 | Input component 0 (red/Cr) |
| pix1_i | input | 10 | Input component 1 (green/Y) |
| pix2_i | input | 10 | Input component 2 (blue/Cb) |
| pix_valid_o | output | 1 | Output pixel valid |
| pix0_o | output | 10 | Output component 0 (Y/G) |
| pix1_o | output | 10 | Output component 1 (Cb/B) |
| pix2_o | output | 10 | Output component 2 (Cr/R) |

## Verification
A weight decoded into the wrong matrix cell, or with its sign handled wrongly, shows up on the first converted pixel whose component for that input is non-zero. The error appears on the output lane of that cell, three clocks after the pixel enters. A mode flag or a valid bit that lags or leads its data puts a bypass value in place of a converted one, or shifts the scoreboard order, on the very next result. A fault in clamping or wrapping only shows once a result leaves 0..1023. The bench therefore drives weights with an integer part and a negative offset to reach those cases.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  localparam int PIX_W  = 10;
  localparam int INT_W  = 6;
  localparam int FRAC_W = 10;
  localparam int OFS_W  = 10;
  localparam int ADDR_W = 4;
  localparam int NCH    = 3;
  localparam int CFG_W  = INT_W + FRAC_W;

  typedef struct packed {
    logic [INT_W-1:0]  ip;  // MSB is sign of the whole weight
    logic [FRAC_W-1:0] fp;
  } coef_t;
endpackage

// File: rtl/csc_cfg_regs.sv
`timescale 1ns/1ps
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int N = NCH
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [CFG_W-1:0]        wdata,
  output coef_t                   coef_o [N*N],
  output logic signed [OFS_W-1:0] ofs_o  [N],
  output logic                    bypass_o,
  output logic                    sat_o
);
  localparam int NCOEF     = N * N;
  localparam int OFS_BASE  = NCOEF;
  localparam int CTRL_ADDR = NCOEF + N;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCOEF; i++) coef_o[i] <= '0;
      for (int j = 0; j < N; j++) ofs_o[j] <= '0;
      bypass_o <= 1'b1;
      sat_o    <= 1'b0;
    end else if (we) begin
      for (int i = 0; i < NCOEF; i++)
        if (addr == ADDR_W'(i)) coef_o[i] <= coef_t'(wdata);
      for (int j = 0; j < N; j++)
        if (addr == ADDR_W'(OFS_BASE + j)) ofs_o[j] <= wdata[OFS_W-1:0];
      if (addr == ADDR_W'(CTRL_ADDR)) begin
        bypass_o <= wdata[0];
        sat_o    <= wdata[1];
      end
    end
  end
endmodule

// File: rtl/csc_lane.sv
`timescale 1ns/1ps
module csc_lane
  import csc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int IW = INT_W,
  parameter int FW = FRAC_W,
  parameter int OW = OFS_W,
  parameter int N  = NCH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en1,
  input  logic                 en2,
  input  logic                 en3,
  input  logic                 byp,
  input  logic                 sat,
  input  logic [PW-1:0]        pix_i  [N],
  input  coef_t                coef_i [N],
  input  logic signed [OW-1:0] ofs_i,
  input  logic [PW-1:0]        thru_i,
  output logic [PW-1:0]        pix_o
);
  localparam int MAG_W  = IW - 1 + FW;
  localparam int PROD_W = PW + MAG_W + 1;
  localparam int ACC_W  = PROD_W + $clog2(N) + 1;
  localparam int RND_W  = ACC_W - FW;
  localparam logic [PW-1:0] MAXV = '1;

  logic signed [PROD_W-1:0] prod_d [N];
  logic signed [PROD_W-1:0] prod_q [N];
  logic signed [ACC_W-1:0]  acc_d, acc_q, ofs_ext, half;
  logic signed [RND_W-1:0]  rnd;
  logic [PW-1:0]            thru1, thru2, clamped;

  // stage 1: sign-magnitude products
  for (genvar k = 0; k < N; k++) begin : g_mul
    logic [MAG_W-1:0]    mag;
    logic [PROD_W-2:0]   um;
    assign mag = {coef_i[k].ip[IW-2:0], coef_i[k].fp};
    assign um  = (PROD_W-1)'(mag) * (PROD_W-1)'(pix_i[k]);
    assign prod_d[k] = coef_i[k].ip[IW-1] ? -$signed({1'b0, um}) : $signed({1'b0, um});
  end

  always_ff @(posedge clk) begin
    if (en1) begin
      prod_q <= prod_d;
      thru1  <= thru_i;
    end
  end

  // stage 2: sum, offset, rounding half
  assign ofs_ext = {{(ACC_W-OW-FW-2){ofs_i[OW-1]}}, ofs_i, {(FW+2){1'b0}}};
  assign half    = ACC_W'(1) <<< (FW - 1);

  always_comb begin
    acc_d = ofs_ext + half;
    for (int k = 0; k < N; k++)
      acc_d = acc_d + {{(ACC_W-PROD_W){prod_q[k][PROD_W-1]}}, prod_q[k]};
  end

  always_ff @(posedge clk) begin
    if (en2) begin
      acc_q <= acc_d;
      thru2 <= thru1;
    end
  end

  // stage 3: scale down, clamp or wrap, bypass select
  assign rnd = acc_q[ACC_W-1:FW];

  always_comb begin
    if (rnd[RND_W-1])            clamped = '0;
    else if (|rnd[RND_W-2:PW])   clamped = MAXV;
    else                         clamped = rnd[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)      pix_o <= '0;
    else if (en3) pix_o <= byp ? thru2 : (sat ? clamped : rnd[PW-1:0]);
  end
endmodule

// File: rtl/colorspace_conv.sv
`timescale 1ns/1ps
module colorspace_conv
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              pix_valid_i,
  input  logic [PIX_W-1:0]  pix0_i,
  input  logic [PIX_W-1:0]  pix1_i,
  input  logic [PIX_W-1:0]  pix2_i,
  output logic              pix_valid_o,
  output logic [PIX_W-1:0]  pix0_o,
  output logic [PIX_W-1:0]  pix1_o,
  output logic [PIX_W-1:0]  pix2_o
);
  coef_t                   coef_all [NCH*NCH];
  logic signed [OFS_W-1:0] ofs_all  [NCH];
  logic                    cfg_bypass, cfg_sat;
  logic [PIX_W-1:0]        pin  [NCH];
  logic [PIX_W-1:0]        pout [NCH];
  logic [2:0]              v_q;
  logic [1:0]              byp_q, sat_q;

  csc_cfg_regs #(.N(NCH)) regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .coef_o(coef_all), .ofs_o(ofs_all), .bypass_o(cfg_bypass), .sat_o(cfg_sat)
  );

  assign pin[0] = pix0_i;
  assign pin[1] = pix1_i;
  assign pin[2] = pix2_i;

  // mode flags travel with the pixel they were sampled for
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= '0;
      byp_q <= '0;
      sat_q <= '0;
    end else begin
      v_q <= {v_q[1:0], pix_valid_i};
      if (pix_valid_i) begin
        byp_q[0] <= cfg_bypass;
        sat_q[0] <= cfg_sat;
      end
      if (v_q[0]) begin
        byp_q[1] <= byp_q[0];
        sat_q[1] <= sat_q[0];
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_lane
    coef_t row [NCH];
    for (genvar k = 0; k < NCH; k++) begin : g_row
      assign row[k] = coef_all[n*NCH + k];
    end
    csc_lane #(.PW(PIX_W), .IW(INT_W), .FW(FRAC_W), .OW(OFS_W), .N(NCH)) lane_i (
      .clk(clk), .rst(rst), .en1(pix_valid_i), .en2(v_q[0]), .en3(v_q[1]),
      .byp(byp_q[1]), .sat(sat_q[1]), .pix_i(pin), .coef_i(row),
      .ofs_i(ofs_all[n]), .thru_i(pin[n]), .pix_o(pout[n])
    );
  end

  assign pix_valid_o = v_q[2];
  assign pix0_o = pout[0];
  assign pix1_o = pout[1];
  assign pix2_o = pout[2];
endmodule

// File: rtl/csc_chk.sv
`timescale 1ns/1ps
module csc_chk
  import csc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             vin,
  input logic [PIX_W-1:0] i0,
  input logic [PIX_W-1:0] i1,
  input logic [PIX_W-1:0] i2,
  input logic             byp,
  input logic             vout,
  input logic [PIX_W-1:0] o0,
  input logic [PIX_W-1:0] o1,
  input logic [PIX_W-1:0] o2
);
  logic [1:0] age = '0;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  // R7
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    vout == $past(vin, 3));

  // R6
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    ($past(vin, 3) && $past(byp, 3)) |->
      (o0 == $past(i0, 3) && o1 == $past(i1, 3) && o2 == $past(i2, 3)));

  // R8
  reset_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!vout && o0 == '0 && o1 == '0 && o2 == '0));

  // R10
  hold_data_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    !vout |-> ($stable(o0) && $stable(o1) && $stable(o2)));
endmodule

bind colorspace_conv csc_chk chk_i (
  .clk(clk), .rst(rst), .vin(pix_valid_i), .i0(pix0_i), .i1(pix1_i), .i2(pix2_i),
  .byp(cfg_bypass), .vout(pix_valid_o), .o0(pix0_o), .o1(pix1_o), .o2(pix2_o)
);

// File: tb/colorspace_conv_tb.sv
`timescale 1ns/1ps
module colorspace_conv_tb_top;
  import csc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [CFG_W-1:0]  cfg_wdata = '0;
  logic pix_valid_i = 1'b0;
  logic [PIX_W-1:0] pix0_i = '0, pix1_i = '0, pix2_i = '0;
  logic pix_valid_o;
  logic [PIX_W-1:0] pix0_o, pix1_o, pix2_o;

  always #4 clk = ~clk;

  colorspace_conv dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid_i(pix_valid_i), .pix0_i(pix0_i), .pix1_i(pix1_i), .pix2_i(pix2_i),
    .pix_valid_o(pix_valid_o), .pix0_o(pix0_o), .pix1_o(pix1_o), .pix2_o(pix2_o)
  );

  typedef struct { int e0; int e1; int e2; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int cint[9], cfr[9], sofs[3];
  bit s_byp = 1, s_sat = 0;
  int last_e[3] = '{0, 0, 0};

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model(int n, int p0, int p1, int p2);
    longint acc = 0;
    int p[3];
    p[0] = p0; p[1] = p1; p[2] = p2;
    if (s_byp) return p[n];
    for (int k = 0; k < 3; k++) begin
      longint t = longint'(p[k]) * longint'((cint[n*3+k] & 31) * 1024 + cfr[n*3+k]);
      if ((cint[n*3+k] & 32) != 0) acc -= t; else acc += t;
    end
    acc += longint'(sofs[n]) * 4096 + 512;
    acc = acc >>> 10;
    if (s_sat) return (acc < 0) ? 0 : ((acc > 1023) ? 1023 : int'(acc));
    return int'(acc & 1023);
  endfunction

  task automatic wr(int addr, int data);
    cfg_we = 1'b1;
    cfg_addr = ADDR_W'(addr);
    cfg_wdata = CFG_W'(data);
    if (addr < 9) begin
      cint[addr] = (data >> 10) & 63;
      cfr[addr]  = data & 1023;
    end else if (addr < 12) begin
      sofs[addr-9] = ((data & 512) != 0) ? (data & 1023) - 1024 : (data & 1023);
    end else if (addr == 12) begin
      s_byp = data[0];
      s_sat = data[1];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_coef(int n, int k, int ip, int fr);
    wr(n*3 + k, (ip << 10) | fr);
  endtask

  task automatic pix(int p0, int p1, int p2, string req);
    exp_t e;
    pix_valid_i = 1'b1;
    pix0_i = PIX_W'(p0); pix1_i = PIX_W'(p1); pix2_i = PIX_W'(p2);
    e.e0 = model(0, p0, p1, p2);
    e.e1 = model(1, p0, p1, p2);
    e.e2 = model(2, p0, p1, p2);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    pix_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pix_valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R7", "result without pending pixel", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(int'(pix0_o) == e.e0, e.req, "out0", int'(pix0_o), e.e0);
        check(int'(pix1_o) == e.e1, e.req, "out1", int'(pix1_o), e.e1);
        check(int'(pix2_o) == e.e2, e.req, "out2", int'(pix2_o), e.e2);
        last_e[0] = e.e0; last_e[1] = e.e1; last_e[2] = e.e2;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) begin cint[i] = 0; cfr[i] = 0; end
    for (int j = 0; j < 3; j++) sofs[j] = 0;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;

    // R8: reset state
    check(pix_valid_o == 1'b0, "R8", "valid after reset", int'(pix_valid_o), 0);
    check(pix0_o == '0 && pix1_o == '0 && pix2_o == '0, "R8", "data after reset",
          int'(pix0_o) + int'(pix1_o) + int'(pix2_o), 0);

    // R8 R6: bypass is on after reset
    pix(100, 200, 300, "R8 R6");
    pix(1023, 0, 512, "R8 R6");
    idle(4);

    // R8: weights and offsets zero after reset
    wr(12, 0);
    pix(1000, 1000, 1000, "R8");
    idle(4);

    // R1 R2 R3: HD RGB to YCbCr weights with mid-scale chroma offsets
    set_coef(1, 1, 32, 404);
    set_coef(0, 2, 0, 74);
    set_coef(2, 0, 0, 524);
    set_coef(0, 0, 0, 218);
    set_coef(2, 2, 32, 48);
    set_coef(1, 0, 32, 120);
    set_coef(0, 1, 0, 732);
    set_coef(2, 1, 32, 476);
    set_coef(1, 2, 0, 524);
    wr(10, 128);
    wr(11, 128);
    wr(9, 0);
    wr(12, 2);
    pix(0, 0, 0, "R1 R3");
    pix(1023, 1023, 1023, "R1 R2");
    pix(1023, 0, 0, "R1 R2");
    pix(0, 1023, 0, "R1 R2");
    pix(0, 0, 1023, "R1 R2");
    pix(512, 256, 768, "R1 R3");
    pix(77, 901, 333, "R1");
    idle(4);

    // R4: weights with integer part push results past both ends
    set_coef(0, 0, 2, 0);
    set_coef(1, 1, 33, 0);
    pix(1023, 1023, 0, "R4");
    pix(600, 900, 100, "R4");
    idle(4);

    // R5: same data with saturation off wraps
    wr(12, 0);
    pix(1023, 1023, 0, "R5");
    pix(600, 900, 100, "R5");
    idle(4);

    // R3: negative offset, wrapped then clamped
    wr(11, (-8) & 1023);
    pix(0, 0, 0, "R3 R5");
    wr(12, 2);
    pix(0, 0, 0, "R3 R4");
    idle(4);

    // R6 R7: bypass with a live matrix, exact latency
    wr(12, 3);
    idle(4);
    pix(5, 6, 7, "R6");
    check(pix_valid_o == 1'b0, "R7", "valid one clock after sample", int'(pix_valid_o), 0);
    idle(1);
    check(pix_valid_o == 1'b0, "R7", "valid two clocks after sample", int'(pix_valid_o), 0);
    idle(1);
    check(pix_valid_o == 1'b1, "R7", "valid three clocks after sample", int'(pix_valid_o), 1);
    pix(1023, 0, 1, "R6");
    pix(321, 654, 987, "R6");
    idle(4);

    // R9: write followed at once by a pixel
    wr(12, 0);
    set_coef(0, 0, 1, 0);
    pix(300, 0, 0, "R9");
    set_coef(0, 0, 0, 512);
    pix(300, 0, 0, "R9");
    idle(5);

    // R10: outputs hold while no result is valid
    idle(6);
    check(pix_valid_o == 1'b0, "R10", "valid while idle", int'(pix_valid_o), 0);
    check(int'(pix0_o) == last_e[0], "R10", "out0 held", int'(pix0_o), last_e[0]);
    check(int'(pix1_o) == last_e[1], "R10", "out1 held", int'(pix1_o), last_e[1]);
    check(int'(pix2_o) == last_e[2], "R10", "out2 held", int'(pix2_o), last_e[2]);

    check(q.size() == 0, "R7", "pending results at end", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule